// File: doc/BRIEF.md
# Phased-Array Transducer Drive Generator

This block drives an ultrasonic phased array. Every transducer channel gets two digital waveforms. The first is a 50% square-wave carrier whose phase within the carrier period is set per channel. The second is an enable line whose duty cycle is set per channel and which gates the channel's full-bridge driver, so it sets output power. The FPGA has far fewer pins than there are waveforms. The bits therefore leave on a few serial lines, each feeding a chain of external 8-bit serial-in/parallel-out shift registers. One common strobe makes all registers in all chains present their new bits at the same moment.

Time is divided into update slots. In each slot the sequencer shifts one register's worth of bits into every chain in parallel and then strobes the latch. A slot is one step of a shared phase counter and of a separate PWM counter. The phase counter spans one carrier period; the PWM counter runs freely over its own range. A host writes phase and power words through a valid/ready port. The port never applies back-pressure: `wr_ready` is always high, and every cycle with `wr_valid` high is one accepted write. A write lands in a shadow copy of the channel's settings. The shadow is promoted to the active set only where the phase counter wraps, so a carrier period is never altered partway through.

Top module: `xdg_drive_gen`

## Requirements
- R1: After reset, `sr_clk`, `sr_latch` and every `sr_data` bit are low, and all phase and power values are zero. The first slot therefore latches every enable bit low.
- R2: In slot k, channel i's carrier bit is 1 exactly when ((k mod 2^PH_W) − phase_i) mod 2^PH_W < 2^(PH_W−1).
- R3: In slot k, channel i's enable bit is 1 exactly when (k mod 2^PWR_W) < power_i.
- R4: A power value of 0 keeps the enable bit low in every slot.
- R5: The largest power value (2^PWR_W − 1) keeps the enable bit high in every slot except the one where the PWM counter is at its maximum.
- R6: Each slot gives exactly SR_W rising edges of `sr_clk` before the latch. Chain c carries packed bits [c*SR_W +: SR_W], highest index first. In the packed vector, channel i's carrier is at bit 2i and its enable is at bit 2i+1.
- R7: `sr_latch` is high for exactly one clock per slot, only after that slot's shifting, and never while `sr_clk` is high.
- R8: A written phase or power value first appears in the slot where the phase counter returns to 0 after the write. Until then the previous value stays in force.
- R9: Packed bits above 2*NUM_CH, which fill the last chain, are always shifted out as 0.
- R10: `wr_ready` is high in every cycle, including during reset.
- R11: A write whose channel index is NUM_CH or above changes no output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Always high; write accepted when valid |
| wr_ch | input | CH_W | Channel index of the write |
| wr_phase | input | PH_W | Phase offset in carrier steps |
| wr_power | input | PWR_W | Enable duty value |
| sr_clk | output | 1 | Shift clock to all chains (data stable while high) |
| sr_latch | output | 1 | Storage strobe to all chains |
| sr_data | output | CHAINS | Serial data, one bit per chain |

## Verification
A slot lasts 2*SR_W+2 clocks, and the outputs are registered one clock behind the sequencer state. The latch therefore rises 2*SR_W+1 clocks after a slot begins. The bench does not predict fixed cycle numbers. It samples at the falling edge, captures bits on the rising edges of `sr_clk` it sees, and evaluates its arithmetic model at each rising edge of `sr_latch`, indexing by slot count. A write is accepted at the next rising edge and changes the latched bits only at the first latch of the next carrier period. The bench issues its writes mid-period, away from the wrap, so the boundary it expects is unambiguous.

// File: rtl/xdg_pkg.sv
package xdg_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/xdg_timebase.sv
module xdg_timebase #(
  parameter int PH_W  = 10,
  parameter int PWR_W = 8,
  parameter int SR_W  = 8,
  localparam int SLOT   = 2 * SR_W + 2,
  localparam int STEP_W = $clog2(SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STEP_W-1:0] step,
  output logic [PH_W-1:0]   phase_cnt,
  output logic [PWR_W-1:0]  pwm_cnt,
  output logic              period_end
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SLOT - 1);

  logic slot_end;
  assign slot_end   = (step == LAST);
  assign period_end = slot_end && (&phase_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      phase_cnt <= '0;
      pwm_cnt   <= '0;
    end else if (slot_end) begin
      step      <= '0;
      phase_cnt <= phase_cnt + 1'b1;
      pwm_cnt   <= pwm_cnt + 1'b1;
    end else begin
      step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/xdg_chan_regs.sv
module xdg_chan_regs #(
  parameter int NUM_CH = 16,
  parameter int PH_W   = 10,
  parameter int PWR_W  = 8,
  parameter int CH_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_fire,
  input  logic [CH_W-1:0]         wr_ch,
  input  logic [PH_W-1:0]         wr_phase,
  input  logic [PWR_W-1:0]        wr_power,
  input  logic                    commit,
  output logic [NUM_CH*PH_W-1:0]  act_phase,
  output logic [NUM_CH*PWR_W-1:0] act_power
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [PH_W-1:0]  sh_phase;
    logic [PWR_W-1:0] sh_power;
    logic             hit;
    assign hit = wr_fire && (wr_ch == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_phase <= '0;
        sh_power <= '0;
        act_phase[i*PH_W +: PH_W]   <= '0;
        act_power[i*PWR_W +: PWR_W] <= '0;
      end else begin
        if (hit) begin
          sh_phase <= wr_phase;
          sh_power <= wr_power;
        end
        if (commit) begin
          act_phase[i*PH_W +: PH_W]   <= sh_phase;
          act_power[i*PWR_W +: PWR_W] <= sh_power;
        end
      end
    end
  end
endmodule

// File: rtl/xdg_compare.sv
module xdg_compare #(
  parameter int NUM_CH = 16,
  parameter int PH_W   = 10,
  parameter int PWR_W  = 8
) (
  input  logic [PH_W-1:0]         phase_cnt,
  input  logic [PWR_W-1:0]        pwm_cnt,
  input  logic [NUM_CH*PH_W-1:0]  act_phase,
  input  logic [NUM_CH*PWR_W-1:0] act_power,
  output logic [2*NUM_CH-1:0]     wave_bits
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    logic [PH_W-1:0] lag;
    assign lag = phase_cnt - act_phase[i*PH_W +: PH_W];
    // carrier high for the first half of the shifted period
    assign wave_bits[2*i]   = ~lag[PH_W-1];
    assign wave_bits[2*i+1] = (pwm_cnt < act_power[i*PWR_W +: PWR_W]);
  end
endmodule

// File: rtl/xdg_drive_gen.sv
module xdg_drive_gen #(
  parameter int NUM_CH = 16,
  parameter int PH_W   = 10,
  parameter int PWR_W  = 8,
  parameter int SR_W   = 8,
  localparam int CH_W   = xdg_pkg::idx_width(NUM_CH),
  localparam int CHAINS = xdg_pkg::ceil_div(2 * NUM_CH, SR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [PH_W-1:0]   wr_phase,
  input  logic [PWR_W-1:0]  wr_power,
  output logic              sr_clk,
  output logic              sr_latch,
  output logic [CHAINS-1:0] sr_data
);
  localparam int SLOT   = 2 * SR_W + 2;
  localparam int STEP_W = $clog2(SLOT);
  localparam int BIT_W  = xdg_pkg::idx_width(SR_W);
  localparam int PAD_W  = CHAINS * SR_W;
  localparam logic [STEP_W-1:0] SHIFT_END = STEP_W'(2 * SR_W);

  logic [STEP_W-1:0]       step;
  logic [PH_W-1:0]         phase_cnt;
  logic [PWR_W-1:0]        pwm_cnt;
  logic                    period_end;
  logic [NUM_CH*PH_W-1:0]  act_phase;
  logic [NUM_CH*PWR_W-1:0] act_power;
  logic [2*NUM_CH-1:0]     wave_bits;
  logic [PAD_W-1:0]        padded;
  logic [CHAINS-1:0]       data_nxt;
  logic                    in_shift;
  logic [BIT_W-1:0]        rev_sel;

  assign wr_ready = 1'b1;

  xdg_timebase #(.PH_W(PH_W), .PWR_W(PWR_W), .SR_W(SR_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .step(step), .phase_cnt(phase_cnt),
    .pwm_cnt(pwm_cnt), .period_end(period_end)
  );

  xdg_chan_regs #(.NUM_CH(NUM_CH), .PH_W(PH_W), .PWR_W(PWR_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid && wr_ready), .wr_ch(wr_ch),
    .wr_phase(wr_phase), .wr_power(wr_power), .commit(period_end),
    .act_phase(act_phase), .act_power(act_power)
  );

  xdg_compare #(.NUM_CH(NUM_CH), .PH_W(PH_W), .PWR_W(PWR_W)) u_cmp (
    .phase_cnt(phase_cnt), .pwm_cnt(pwm_cnt), .act_phase(act_phase),
    .act_power(act_power), .wave_bits(wave_bits)
  );

  assign padded   = PAD_W'(wave_bits);
  assign in_shift = (step < SHIFT_END);
  // highest bit of each register goes out first
  assign rev_sel  = BIT_W'(SR_W - 1) - step[BIT_W:1];

  for (genvar c = 0; c < CHAINS; c++) begin : g_chain
    logic [SR_W-1:0] word;
    assign word        = padded[c*SR_W +: SR_W];
    assign data_nxt[c] = word[rev_sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_clk   <= 1'b0;
      sr_latch <= 1'b0;
      sr_data  <= '0;
    end else begin
      sr_clk   <= in_shift && step[0];
      sr_latch <= (step == SHIFT_END);
      sr_data  <= in_shift ? data_nxt : '0;
    end
  end
endmodule

// File: rtl/xdg_drive_gen_chk.sv
module xdg_drive_gen_chk #(
  parameter int CHAINS = 4,
  parameter int PH_W   = 10,
  parameter int ACT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_clk,
  input logic              sr_latch,
  input logic [CHAINS-1:0] sr_data,
  input logic [PH_W-1:0]   phase_cnt,
  input logic [ACT_W-1:0]  act_all
);
  assert_latch_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_latch |=> !sr_latch);

  assert_latch_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr_latch |-> !sr_clk);

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clk |-> $stable(sr_data));

  assert_commit_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_all) |-> (phase_cnt == '0));
endmodule

bind xdg_drive_gen xdg_drive_gen_chk #(
  .CHAINS(CHAINS), .PH_W(PH_W), .ACT_W(NUM_CH*(PH_W+PWR_W))
) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_clk(sr_clk), .sr_latch(sr_latch),
  .sr_data(sr_data), .phase_cnt(phase_cnt), .act_all({act_phase, act_power})
);

// File: tb/tb_xdg_drive_gen.sv
module tb_xdg_drive_gen;
  localparam int NCH = 5, PHW = 4, PWW = 3, SRW = 8, CHW = 3, CHN = 2;
  localparam int PER = 1 << PHW, PWM_PER = 1 << PWW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           wr_valid = 1'b0;
  logic           wr_ready;
  logic [CHW-1:0] wr_ch = '0;
  logic [PHW-1:0] wr_phase = '0;
  logic [PWW-1:0] wr_power = '0;
  logic           sr_clk, sr_latch;
  logic [CHN-1:0] sr_data;

  xdg_drive_gen #(.NUM_CH(NCH), .PH_W(PHW), .PWR_W(PWW), .SR_W(SRW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ch(wr_ch), .wr_phase(wr_phase), .wr_power(wr_power),
    .sr_clk(sr_clk), .sr_latch(sr_latch), .sr_data(sr_data)
  );

  int n_chk = 0, n_fail = 0, slot_k = 0, clk_rises = 0;
  logic prev_clk = 1'b0, prev_lat = 1'b0;
  logic [SRW-1:0] chain_sr [CHN];
  int sh_ph [NCH], sh_pw [NCH], ac_ph [NCH], ac_pw [NCH];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic latch_event();
    int idx, pwm, lag;
    logic [CHN*SRW-1:0] flat, expv;
    string tag;
    idx = slot_k % PER;
    pwm = slot_k % PWM_PER;
    if (idx == 0 && slot_k > 0)
      for (int i = 0; i < NCH; i++) begin ac_ph[i] = sh_ph[i]; ac_pw[i] = sh_pw[i]; end
    check(clk_rises == SRW, "R6 shift clocks per slot", clk_rises, SRW);
    clk_rises = 0;
    for (int c = 0; c < CHN; c++) flat[c*SRW +: SRW] = chain_sr[c];
    expv = '0;
    for (int i = 0; i < NCH; i++) begin
      lag = (idx - ac_ph[i] + PER) % PER;
      expv[2*i]   = (lag < PER / 2);
      expv[2*i+1] = (pwm < ac_pw[i]);
      tag = (sh_ph[i] != ac_ph[i]) ? "R8 carrier before wrap" : "R2 carrier";
      check(flat[2*i] == expv[2*i], tag, int'(flat[2*i]), int'(expv[2*i]));
      if (slot_k == 0) tag = "R1 enable after reset";
      else if (sh_pw[i] != ac_pw[i]) tag = "R8 enable before wrap";
      else if (ac_pw[i] == 0) tag = "R4 zero power";
      else if (ac_pw[i] == PWM_PER - 1) tag = "R5 full power";
      else tag = "R3 enable duty";
      check(flat[2*i+1] == expv[2*i+1], tag, int'(flat[2*i+1]), int'(expv[2*i+1]));
    end
    check(flat[CHN*SRW-1:2*NCH] == '0, "R9 padding bits", int'(flat[CHN*SRW-1:2*NCH]), 0);
    check(flat == expv, "R11 whole vector", int'(flat), int'(expv));
    slot_k++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sr_clk && !prev_clk) begin
        for (int c = 0; c < CHN; c++) chain_sr[c] = {chain_sr[c][SRW-2:0], sr_data[c]};
        clk_rises++;
      end
      if (sr_latch)
        check(!prev_lat && !sr_clk, "R7 latch single and clock low",
              int'({prev_lat, sr_clk}), 0);
      if (sr_latch && !prev_lat) latch_event();
      prev_clk = sr_clk;
      prev_lat = sr_latch;
    end
  end

  task automatic do_write(input int ch, input int ph, input int pw);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_ch    = CHW'(ch);
    wr_phase = PHW'(ph);
    wr_power = PWW'(pw);
    if (ch < NCH) begin sh_ph[ch] = ph; sh_pw[ch] = pw; end
  endtask

  initial begin
    for (int c = 0; c < CHN; c++) chain_sr[c] = '0;
    for (int i = 0; i < NCH; i++) begin sh_ph[i] = 0; sh_pw[i] = 0; ac_ph[i] = 0; ac_pw[i] = 0; end
    repeat (4) @(negedge clk);
    check(!sr_clk && !sr_latch && sr_data == '0, "R1 outputs in reset",
          int'({sr_clk, sr_latch, sr_data}), 0);
    check(wr_ready, "R10 ready in reset", int'(wr_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sr_clk && !sr_latch, "R1 latch idle after reset", int'({sr_clk, sr_latch}), 0);
    for (int r = 0; r < 12; r++) begin
      int target;
      wait (slot_k % PER == 5);
      for (int i = 0; i < NCH; i++) do_write(i, (r * 7 + i * 3 + r * r) % PER, (r + i * 2) % PWM_PER);
      do_write(7, 9, 7);
      do_write(NCH, 3, 5);
      @(negedge clk);
      wr_valid = 1'b0;
      check(wr_ready, "R10 ready after writes", int'(wr_ready), 1);
      target = slot_k + 2 * PER;
      wait (slot_k >= target);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", slot_k, 12 * 2 * PER);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule